// File: doc/BRIEF.md
# Scatter-Gather Copy Engine

This block copies data from card-side memory to host-side memory by walking a table of transfer descriptors. Software places the table in memory, presents the table's byte address on `table_base_i` and pulses `start_i`. The engine then reads each descriptor, checks its byte count, and moves the data word by word through a single word-wide memory port. Each descriptor's payload is handled in bursts of up to 64 words: the engine reads a burst into a local store and then writes it out.

After the descriptor that carries the end flag has been copied, the engine stops fetching, sets its completion status bits and pulses an interrupt. A bad byte count, an error response from memory, or a table with no end flag within a fixed number of entries stops the run early. In each of these cases the matching error bit is set and the interrupt still fires. Software clears the status bits by writing ones to them.

The memory port carries one request at a time. The engine holds `mem_req_o`, together with the address, direction and write data, until `mem_ready_i` is high at a clock edge. The memory then returns exactly one response (`mem_rsp_i`, with `mem_err_i` and, for reads, `mem_rdata_i`) in a later cycle. Words are 32 bits wide and little-endian: the byte at the lowest address sits in bits [7:0]. Data words are passed through unchanged.

Top module: `sg_copy_engine`

## Requirements
- R1: A descriptor is three words at its address +0, +4 and +8, read in that order: the source byte address, the destination byte address, then the control word. In the control word, bits [17:0] are the byte count, bit 31 is the end flag, and bits [30:18] are ignored. The next descriptor starts 12 bytes further on.
- R2: A valid descriptor copies count/4 words. Source and destination addresses both rise by 4 for each word. Each word is written with the same value that was read.
- R3: Data reads are grouped into bursts of at most 64 words, and all reads of a burst come before its writes. A 128-word descriptor gives two runs of exactly 64 reads.
- R4: When the descriptor with the end flag finishes, the engine sets status bit 0 (read done) and bit 1 (write done) and makes `irq_o` high for exactly one cycle. It issues no further requests and fetches no further descriptors.
- R5: A byte count that is zero, or whose bits [7:0] are not all zero, sets status bit 4 (table error). The engine then ends the run with the interrupt and moves no data for that descriptor.
- R6: An error response to any read, whether a descriptor read or a data read, sets status bit 2 and ends the run with the interrupt. No later request is issued.
- R7: An error response to a data write sets status bit 3 and ends the run with the interrupt.
- R8: If MAX_DESC descriptors finish and none has the end flag, the engine sets status bit 4 and ends the run without fetching another descriptor.
- R9: Status bits stay set until a 1 is written to them on `stat_clr_i`. If a bit is set and cleared in the same cycle, the set wins.
- R10: `busy_o` goes high in the cycle after an accepted start and stays high until the interrupt cycle. A start pulse while busy is ignored.
- R11: After reset, the status is 0 and `busy_o`, `irq_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start pulse |
| table_base_i | input | 32 | Byte address of the first descriptor, taken at start |
| stat_clr_i | input | 5 | Write-one-to-clear mask for the status bits |
| stat_o | output | 5 | Status: 0 read done, 1 write done, 2 read error, 3 write error, 4 table error |
| busy_o | output | 1 | A run is in progress |
| irq_o | output | 1 | One-cycle pulse at the end of a run |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted at this edge |
| mem_rsp_i | input | 1 | Response valid |
| mem_err_i | input | 1 | Response carries an error |
| mem_rdata_i | input | 32 | Read response data |

## Verification
The end of a run sets status bits. A software write-one-to-clear can arrive in that same cycle and aim at the same bits. The bench holds `stat_clr_i` at all ones for the whole of a run. It then checks that the bits are visible in the same cycle as the interrupt pulse, and that they are cleared one cycle later. The bench also provokes a second overlap by pulsing start, with a different table base, while a run is still copying. It then checks that the first table's results stand and that the second table is never read.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned DESC_WORDS = 3;
    localparam int unsigned CNT_W      = 18;
    localparam int unsigned ST_W       = 5;

    localparam int unsigned ST_RD_DONE = 0;
    localparam int unsigned ST_WR_DONE = 1;
    localparam int unsigned ST_RD_ERR  = 2;
    localparam int unsigned ST_WR_ERR  = 3;
    localparam int unsigned ST_TBL_ERR = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FREQ,
        S_FWAIT,
        S_CHECK,
        S_RREQ,
        S_RWAIT,
        S_WREQ,
        S_WWAIT
    } eng_state_e;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] ctl;
    } sg_desc_t;

    function automatic logic [CNT_W-1:0] ctl_count(input logic [31:0] c);
        return c[CNT_W-1:0];
    endfunction

    function automatic logic ctl_last(input logic [31:0] c);
        return c[31];
    endfunction

endpackage

// File: rtl/sgd_desc_check.sv
module sgd_desc_check
    import sgd_pkg::*;
#(
    parameter int unsigned GRAIN_BITS = 8
) (
    input  logic [31:0]      ctl_i,
    output logic             ok_o,
    output logic             last_o,
    output logic [CNT_W-3:0] words_o
);
    logic [CNT_W-1:0] cnt;
    logic             unused_rsvd;

    assign cnt         = ctl_count(ctl_i);
    assign unused_rsvd = ^ctl_i[30:CNT_W];
    assign ok_o        = (cnt != '0) && (cnt[GRAIN_BITS-1:0] == '0);
    assign last_o      = ctl_last(ctl_i);
    assign words_o     = cnt[CNT_W-1:2];
endmodule

// File: rtl/sgd_burst_buf.sv
module sgd_burst_buf #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 32,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [IW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [IW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            store[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = store[raddr_i];
endmodule

// File: rtl/sgd_status.sv
module sgd_status #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else begin
            q_o <= (q_o & ~clr_i) | set_i;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))) else $error("set lost"); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|(q_o & ~clr_i)) |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i))) else $error("bit dropped"); // R9
endmodule

// File: rtl/sg_copy_engine.sv
module sg_copy_engine
    import sgd_pkg::*;
#(
    parameter int unsigned MAX_DESC    = 256,
    parameter int unsigned BURST_WORDS = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [31:0]     table_base_i,
    input  logic [ST_W-1:0] stat_clr_i,
    output logic [ST_W-1:0] stat_o,
    output logic            busy_o,
    output logic            irq_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [31:0]     mem_addr_o,
    output logic [31:0]     mem_wdata_o,
    input  logic            mem_ready_i,
    input  logic            mem_rsp_i,
    input  logic            mem_err_i,
    input  logic [31:0]     mem_rdata_i
);
    localparam int unsigned IDX_W  = $clog2(BURST_WORDS);
    localparam int unsigned LEN_W  = $clog2(BURST_WORDS + 1);
    localparam int unsigned WCNT_W = CNT_W - 2;
    localparam int unsigned DCNT_W = $clog2(MAX_DESC + 1);
    localparam logic [31:0] STEP   = 32'(WORD_BYTES);
    localparam logic [31:0] DSTEP  = 32'(DESC_WORDS * WORD_BYTES);

    eng_state_e          state_q, state_d;
    sg_desc_t            desc_q;
    logic [31:0]         ptr_q;
    logic [1:0]          fidx_q;
    logic [WCNT_W-1:0]   words_q;
    logic [LEN_W-1:0]    len_q;
    logic [IDX_W-1:0]    bidx_q;
    logic [DCNT_W-1:0]   dcnt_q;
    logic                irq_q;
    logic [ST_W-1:0]     set_v;

    logic                chk_ok, chk_last;
    logic [WCNT_W-1:0]   chk_words;
    logic [31:0]         buf_rdata;
    logic                acc, rsp_ok, rsp_bad, burst_end, desc_end;
    logic [WCNT_W-1:0]   words_rem;

    function automatic logic [LEN_W-1:0] burst_of(input logic [WCNT_W-1:0] w);
        return (w < WCNT_W'(BURST_WORDS)) ? LEN_W'(w) : LEN_W'(BURST_WORDS);
    endfunction

    sgd_desc_check #(.GRAIN_BITS(8)) u_check (
        .ctl_i   (desc_q.ctl),
        .ok_o    (chk_ok),
        .last_o  (chk_last),
        .words_o (chk_words)
    );

    sgd_burst_buf #(.DEPTH(BURST_WORDS), .DW(32)) u_buf (
        .clk     (clk),
        .we_i    (state_q == S_RWAIT && rsp_ok),
        .waddr_i (bidx_q),
        .wdata_i (mem_rdata_i),
        .raddr_i (bidx_q),
        .rdata_o (buf_rdata)
    );

    sgd_status #(.W(ST_W)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v),
        .clr_i (stat_clr_i),
        .q_o   (stat_o)
    );

    assign acc       = mem_req_o && mem_ready_i;
    assign rsp_ok    = mem_rsp_i && !mem_err_i;
    assign rsp_bad   = mem_rsp_i && mem_err_i;
    assign burst_end = (LEN_W'(bidx_q) + LEN_W'(1)) == len_q;
    assign words_rem = words_q - WCNT_W'(len_q);
    assign desc_end  = burst_end && (words_rem == '0);

    always_comb begin
        state_d = state_q;
        set_v   = '0;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_FREQ;
            S_FREQ:  if (acc) state_d = S_FWAIT;
            S_FWAIT: begin
                if (rsp_bad) begin
                    set_v[ST_RD_ERR] = 1'b1;
                    state_d = S_IDLE;
                end else if (rsp_ok) begin
                    state_d = (fidx_q == 2'(DESC_WORDS - 1)) ? S_CHECK : S_FREQ;
                end
            end
            S_CHECK: begin
                if (!chk_ok) begin
                    set_v[ST_TBL_ERR] = 1'b1;
                    state_d = S_IDLE;
                end else begin
                    state_d = S_RREQ;
                end
            end
            S_RREQ:  if (acc) state_d = S_RWAIT;
            S_RWAIT: begin
                if (rsp_bad) begin
                    set_v[ST_RD_ERR] = 1'b1;
                    state_d = S_IDLE;
                end else if (rsp_ok) begin
                    state_d = burst_end ? S_WREQ : S_RREQ;
                end
            end
            S_WREQ:  if (acc) state_d = S_WWAIT;
            S_WWAIT: begin
                if (rsp_bad) begin
                    set_v[ST_WR_ERR] = 1'b1;
                    state_d = S_IDLE;
                end else if (rsp_ok) begin
                    if (!burst_end) begin
                        state_d = S_WREQ;
                    end else if (!desc_end) begin
                        state_d = S_RREQ;
                    end else if (chk_last) begin
                        set_v[ST_RD_DONE] = 1'b1;
                        set_v[ST_WR_DONE] = 1'b1;
                        state_d = S_IDLE;
                    end else if (dcnt_q == DCNT_W'(MAX_DESC)) begin
                        set_v[ST_TBL_ERR] = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        state_d = S_FREQ;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            desc_q  <= '0;
            ptr_q   <= '0;
            fidx_q  <= '0;
            words_q <= '0;
            len_q   <= '0;
            bidx_q  <= '0;
            dcnt_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= (state_q != S_IDLE) && (state_d == S_IDLE);
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    ptr_q  <= table_base_i;
                    fidx_q <= '0;
                    dcnt_q <= '0;
                end
                S_FWAIT: if (rsp_ok) begin
                    unique case (fidx_q)
                        2'd0:    desc_q.src <= mem_rdata_i;
                        2'd1:    desc_q.dst <= mem_rdata_i;
                        default: desc_q.ctl <= mem_rdata_i;
                    endcase
                    fidx_q <= fidx_q + 2'd1;
                end
                S_CHECK: if (chk_ok) begin
                    words_q <= chk_words;
                    len_q   <= burst_of(chk_words);
                    bidx_q  <= '0;
                    fidx_q  <= '0;
                    dcnt_q  <= dcnt_q + DCNT_W'(1);
                end
                S_RWAIT: if (rsp_ok) begin
                    desc_q.src <= desc_q.src + STEP;
                    bidx_q     <= burst_end ? '0 : bidx_q + IDX_W'(1);
                end
                S_WWAIT: if (rsp_ok) begin
                    desc_q.dst <= desc_q.dst + STEP;
                    if (burst_end) begin
                        bidx_q  <= '0;
                        words_q <= words_rem;
                        len_q   <= burst_of(words_rem);
                        if (desc_end) ptr_q <= ptr_q + DSTEP;
                    end else begin
                        bidx_q <= bidx_q + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            S_FREQ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ptr_q + (32'(fidx_q) << 2);
            end
            S_RREQ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q.src;
            end
            S_WREQ: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_q.dst;
                mem_wdata_o = buf_rdata;
            end
            default: ;
        endcase
    end

    assign busy_o = (state_q != S_IDLE);
    assign irq_o  = irq_q;

    AST_IRQ_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (!busy_o && $past(busy_o))) else $error("irq without run"); // R4
    AST_IRQ_WITH_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (stat_o != '0)) else $error("irq with empty status"); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req_o) else $error("request while idle"); // R4
    AST_BAD_COUNT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CHECK && !chk_ok) |=> (!busy_o && stat_o[ST_TBL_ERR])) else $error("bad count copied"); // R5
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RREQ) |-> (len_q != '0 && len_q <= LEN_W'(BURST_WORDS))) else $error("burst length"); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + DSTEP)) else $error("restart while busy"); // R10
endmodule

// File: tb/sg_copy_engine_tb.sv
`timescale 1ns/1ps
module sg_copy_engine_tb;
    localparam int MAXD = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] base;
    logic [4:0]  clr;
    logic [4:0]  stat;
    logic        busy, irq;
    logic        mreq, mwe, mready, mrsp, merr;
    logic [31:0] maddr, mwdata, mrdata;

    always #10 clk = ~clk;

    sg_copy_engine #(.MAX_DESC(MAXD), .BURST_WORDS(64)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .table_base_i(base),
        .stat_clr_i(clr), .stat_o(stat), .busy_o(busy), .irq_o(irq),
        .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
        .mem_ready_i(mready), .mem_rsp_i(mrsp), .mem_err_i(merr), .mem_rdata_i(mrdata)
    );

    // memory model, monitor and host-side write port
    logic [31:0] mem [0:4095];
    logic        hw_we;
    logic [31:0] hw_addr, hw_data;
    logic        mon_clr;
    logic [31:0] err_rd, err_wr;
    logic [31:0] max_tbl;
    int          wr_cnt, run_len, max_run;
    logic [7:0]  cyc;

    assign mready = (cyc[1:0] != 2'b11);

    always @(posedge clk) begin
        cyc  <= rst ? 8'd0 : cyc + 8'd1;
        mrsp <= 1'b0;
        merr <= 1'b0;
        if (hw_we) mem[hw_addr[13:2]] <= hw_data;
        if (mon_clr) begin
            wr_cnt <= 0; run_len <= 0; max_run <= 0; max_tbl <= 32'h0;
        end else if (mreq && mready) begin
            mrsp <= 1'b1;
            if (mwe) begin
                wr_cnt  <= wr_cnt + 1;
                run_len <= 0;
                if (maddr == err_wr) merr <= 1'b1;
                else mem[maddr[13:2]] <= mwdata;
            end else begin
                mrdata <= mem[maddr[13:2]];
                if (maddr == err_rd) merr <= 1'b1;
                if (maddr >= 32'h1000) begin
                    run_len <= run_len + 1;
                    if (run_len + 1 > max_run) max_run <= run_len + 1;
                end else if (maddr > max_tbl) begin
                    max_tbl <= maddr;
                end
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
        hw_we = 1'b1; hw_addr = a; hw_data = d;
        @(posedge clk); #1;
        hw_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] t, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        host_wr(t, s); host_wr(t + 4, d); host_wr(t + 8, c);
    endtask

    task automatic prep(input logic [31:0] s, input logic [31:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            host_wr(s + 32'(4 * i), pat(s + 32'(4 * i)));
            host_wr(d + 32'(4 * i), 32'h0);
        end
    endtask

    task automatic region(input string req, input logic [31:0] s, input logic [31:0] d, input int n, input int nw);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (mem[(d[13:2]) + 12'(i)] !== ((i < nw) ? pat(s + 32'(4 * i)) : 32'h0)) bad++;
        end
        chk(req, "data words wrong", 32'(bad), 32'h0);
    endtask

    task automatic run(input logic [31:0] b);
        int n = 0;
        mon_clr = 1'b1;
        @(posedge clk); #1;
        mon_clr = 1'b0;
        start = 1'b1; base = b;
        @(posedge clk); #1;
        start = 1'b0;
        chk("R10", "busy after start", 32'(busy), 32'h1);
        while (!irq && n < 20000) begin
            @(posedge clk); #1;
            n++;
        end
        if (!irq) chk("R4", "irq timeout", 32'h0, 32'h1);
    endtask

    task automatic clear_all();
        clr = 5'h1F;
        @(posedge clk); #1;
        clr = 5'h0;
    endtask

    localparam int NV = 6;
    localparam logic [31:0] VEC_CTL [NV] = '{
        32'h8000_0100, 32'h8000_0200, 32'hFFFC_0100,
        32'h8000_0180, 32'h8000_0000, 32'h8000_0001 };
    localparam logic [4:0] VEC_ST [NV] = '{
        5'h03, 5'h03, 5'h03, 5'h10, 5'h10, 5'h10 };

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; base = '0; clr = '0;
        hw_we = 1'b0; hw_addr = '0; hw_data = '0; mon_clr = 1'b1;
        err_rd = 32'hFFFF_FFFF; err_wr = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        mon_clr = 1'b0;
        chk("R11", "status after reset", 32'(stat), 32'h0);
        chk("R11", "busy after reset", 32'(busy), 32'h0);
        chk("R11", "irq after reset", 32'(irq), 32'h0);
        chk("R11", "req after reset", 32'(mreq), 32'h0);

        // table of single-descriptor runs: R1 reserved bits, R2/R3 copy, R5 bad counts
        for (int v = 0; v < NV; v++) begin
            int nw;
            nw = (VEC_ST[v] == 5'h03) ? int'(VEC_CTL[v][17:2]) : 0;
            put_desc(32'h0, 32'h1000, 32'h2000, VEC_CTL[v]);
            prep(32'h1000, 32'h2000, 128);
            run(32'h0);
            chk((v == 2) ? "R1" : ((nw == 0) ? "R5" : "R2"), "status", 32'(stat), 32'(VEC_ST[v]));
            region((nw == 0) ? "R5" : "R2", 32'h1000, 32'h2000, 128, nw);
            chk("R3", "longest read run", 32'(max_run), (nw == 0) ? 32'h0 : 32'd64);
            clear_all();
            chk("R9", "status after clear", 32'(stat), 32'h0);
        end

        // chain of three, end flag on the third; a fourth valid entry must not be read (R1, R4)
        put_desc(32'h100, 32'h1000, 32'h2000, 32'h0000_0100);
        put_desc(32'h10C, 32'h1400, 32'h2400, 32'h0000_0100);
        put_desc(32'h118, 32'h1800, 32'h2800, 32'h8000_0100);
        put_desc(32'h124, 32'h1C00, 32'h2C00, 32'h8000_0100);
        prep(32'h1000, 32'h2000, 64);
        prep(32'h1400, 32'h2400, 64);
        prep(32'h1800, 32'h2800, 64);
        prep(32'h1C00, 32'h2C00, 64);
        run(32'h100);
        chk("R4", "chain status", 32'(stat), 32'h03);
        region("R1", 32'h1000, 32'h2000, 64, 64);
        region("R1", 32'h1400, 32'h2400, 64, 64);
        region("R2", 32'h1800, 32'h2800, 64, 64);
        region("R4", 32'h1C00, 32'h2C00, 64, 0);
        chk("R4", "highest table read", max_tbl, 32'h120);
        @(posedge clk); #1;
        chk("R4", "irq one cycle", 32'(irq), 32'h0);
        chk("R4", "no request after end", 32'(mreq), 32'h0);
        clear_all();

        // start while busy, pointing at a bad table (R10)
        put_desc(32'h200, 32'h1000, 32'h2000, 32'h8000_0200);
        put_desc(32'h300, 32'h1400, 32'h2400, 32'h8000_0080);
        prep(32'h1000, 32'h2000, 128);
        mon_clr = 1'b1; @(posedge clk); #1; mon_clr = 1'b0;
        start = 1'b1; base = 32'h200;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (20) @(posedge clk);
        #1 start = 1'b1; base = 32'h300;
        @(posedge clk); #1;
        start = 1'b0;
        for (int k = 0; k < 20000 && !irq; k++) begin
            @(posedge clk); #1;
        end
        chk("R10", "status after ignored start", 32'(stat), 32'h03);
        chk("R10", "second table untouched", max_tbl, 32'h208);
        region("R10", 32'h1000, 32'h2000, 128, 128);
        clear_all();

        // read error on a descriptor word (R6)
        put_desc(32'h400, 32'h1000, 32'h2000, 32'h8000_0100);
        err_rd = 32'h404;
        run(32'h400);
        chk("R6", "fetch error status", 32'(stat), 32'h04);
        chk("R6", "no writes", 32'(wr_cnt), 32'h0);
        clear_all();

        // read error in the second burst (R6)
        put_desc(32'h400, 32'h1000, 32'h2000, 32'h8000_0200);
        err_rd = 32'h1000 + 32'(4 * 70);
        run(32'h400);
        chk("R6", "data read error status", 32'(stat), 32'h04);
        chk("R6", "writes before abort", 32'(wr_cnt), 32'd64);
        @(posedge clk); #1;
        chk("R6", "no request after abort", 32'(mreq), 32'h0);
        err_rd = 32'hFFFF_FFFF;
        clear_all();

        // write error on the third word (R7)
        prep(32'h1000, 32'h2000, 64);
        err_wr = 32'h2008;
        run(32'h400);
        chk("R7", "write error status", 32'(stat), 32'h08);
        chk("R7", "writes before abort", 32'(wr_cnt), 32'd3);
        err_wr = 32'hFFFF_FFFF;
        clear_all();

        // no end flag within MAX_DESC entries (R8)
        for (int k = 0; k < 5; k++) begin
            put_desc(32'h500 + 32'(12 * k), 32'h1000 + 32'(256 * k), 32'h2000 + 32'(256 * k), 32'h0000_0100);
            prep(32'h1000 + 32'(256 * k), 32'h2000 + 32'(256 * k), 64);
        end
        run(32'h500);
        chk("R8", "limit status", 32'(stat), 32'h10);
        region("R8", 32'h1300, 32'h2300, 64, 64);
        region("R8", 32'h1400, 32'h2400, 64, 0);
        chk("R8", "highest table read", max_tbl, 32'h52C);
        clear_all();

        // clear held during the completion cycle: set wins, then cleared (R9)
        put_desc(32'h0, 32'h1000, 32'h2000, 32'h8000_0100);
        clr = 5'h1F;
        run(32'h0);
        chk("R9", "status in irq cycle", 32'(stat), 32'h03);
        @(posedge clk); #1;
        chk("R9", "status one cycle later", 32'(stat), 32'h0);
        clr = 5'h0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule